// File: doc/BRIEF.md
# Dual-Buffer Transmit Frame Front End

This block sits between a processor's register bus and the byte-wide transmit input of a simple Ethernet MAC. It holds two frame buffers, called ping and pong, that live in one address window: pong starts 0x800 bytes above ping, and inside each half the data area comes first, with a length word and a control/status word near the top. Software picks a buffer whose busy flag is clear, writes the frame into the data area, writes the byte count, and then sets busy. The block reads the stored words back, splits them into bytes with the most significant byte first, and hands them to the MAC over a valid/ready byte stream. When the last byte is accepted it clears busy and, if the buffer's interrupt enable is set, pulses an interrupt for one cycle.

The same machinery loads the 48-bit station address. When busy and the program bit are written together, the block fetches the first six bytes of that buffer, places them on the station address output, and clears both bits without sending anything on the stream. Software can cancel a buffer at any time by writing zero to its status word. Bit 31 of each status word is a scratch flag for software and has no effect on the hardware.

Top module: `dualbuf_tx`

## Requirements
- R1: After reset, both status words and both length words read 0, `tx_valid` is 0 and `station_addr` is 0.
- R2: Bit 11 of `bus_addr` selects ping (0) or pong (1). Within a buffer, byte offset 0x7F4 is the length word and 0x7FC the status word, and offsets below 0x7F4 are frame data. The length word reads back its low 16 bits with the upper 16 bits as 0. The status word reads busy at bit 0, program at bit 1, interrupt enable at bit 3 and the software flag at bit 31, and all other bits as 0. `bus_rdata` is valid in the cycle after `bus_rd` is sampled.
- R3: Writing a 1 to status bit 0 of an idle buffer emits exactly the programmed number of bytes on `tx_data`. The byte at the lowest address goes first, with bits 31:24 of a data word before bits 23:16. `tx_last` is 1 on the final byte only, and the byte, `tx_last` and `tx_valid` hold steady while `tx_ready` is 0.
- R4: Status bit 0 of the sending buffer reads 0 once its last byte has been accepted.
- R5: `tx_irq` is a one-cycle pulse raised when a frame ends with status bit 3 set. No pulse occurs when bit 3 is clear, when a program command ends or when a buffer is cancelled.
- R6: Writing status bits 0 and 1 together loads the first six bytes of that buffer into `station_addr`, with byte 0 at bits 47:40. This happens whatever the length word holds. Nothing appears on the byte stream, and afterwards bits 0 and 1 read 0.
- R7: Status bit 31 reads back as written. Writing it without bit 0 starts no transmission and leaves busy at 0.
- R8: When a frame is launched while the other buffer is still sending, the two frames go out one after the other, in the order their busy bits were set, with no interleaving.
- R9: While a buffer's busy bit is 1, writes to its data area and to its length word are ignored.
- R10: Writing a status word with bit 0 equal to 0 returns that buffer to idle. Busy reads 0, any frame in progress from it stops with no further bytes and no interrupt, and the buffer can be launched again afterwards.
- R11: A length of 0 completes at once with no bytes sent, and busy clears. A length larger than the data area (0x7F4 bytes) sends exactly 0x7F4 bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register bus write strobe |
| bus_rd | input | 1 | Register bus read strobe |
| bus_addr | input | ADDR_W (12) | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| tx_valid | output | 1 | Byte available on `tx_data` |
| tx_ready | input | 1 | MAC accepts the byte |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_irq | output | 1 | One-cycle frame-done interrupt |
| station_addr | output | 48 | Loaded station address |

## Verification
The bench stalls the byte stream in the middle of words. A design that advanced its byte pointer without a handshake would drop or repeat bytes, and one that got the byte order wrong would send each word reversed. It launches pong while ping is still sending and checks that the two frames come out back to back in launch order. It overwrites the data and length of a buffer that is still in flight, where a design without the guard would send the corrupted bytes or a shortened frame. It cancels a stalled frame and expects silence and no interrupt. It loads a station address with a length of 9 and expects six bytes taken and none sent. It also covers the zero-length and oversized-length cases, where a design without the clamp would run past the data area.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

  localparam int ST_BUSY = 0;
  localparam int ST_PROG = 1;
  localparam int ST_IE   = 3;
  localparam int ST_FLAG = 31;

  localparam int LEN_W = 16;

  typedef enum logic [2:0] {
    E_IDLE,
    E_FETCH,
    E_WAIT,
    E_SEND,
    E_FIN
  } eng_state_t;

  typedef struct packed {
    logic             busy;
    logic             prog;
    logic             taken;
    logic             ie;
    logic             flag;
    logic [LEN_W-1:0] len;
  } bufst_t;

  function automatic logic [7:0] be_byte(input logic [31:0] w, input logic [1:0] i);
    case (i)
      2'd0:    return w[31:24];
      2'd1:    return w[23:16];
      2'd2:    return w[15:8];
      default: return w[7:0];
    endcase
  endfunction

endpackage

// File: rtl/dbt_ram.sv
module dbt_ram #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/dbt_regs.sv
module dbt_regs
  import dbt_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              ram_we,
  output logic [ADDR_W-3:0] ram_waddr,
  output logic [31:0]       ram_wdata,
  input  logic              eng_idle,
  output logic              start_fire,
  output logic              start_buf,
  output logic [LEN_W-1:0]  start_len,
  output logic              start_prog,
  input  logic              done,
  input  logic              done_buf,
  output logic [1:0]        kill,
  output logic [1:0]        busy_v,
  output logic [1:0]        ie_v,
  output logic              tx_irq
);

  localparam int SPAN = 1 << (ADDR_W - 1);
  localparam logic [ADDR_W-2:0] LEN_OFS  = (ADDR_W-1)'(SPAN - 12);
  localparam logic [ADDR_W-2:0] STAT_OFS = (ADDR_W-1)'(SPAN - 4);
  localparam logic [LEN_W-1:0]  DATA_BYTES = LEN_W'(SPAN - 12);

  logic              sel_b;
  logic [ADDR_W-2:0] ofs;
  logic              hit_len, hit_stat, hit_data;
  bufst_t            st [2];
  logic [1:0]        pend;

  always_comb begin
    sel_b    = bus_addr[ADDR_W-1];
    ofs      = {bus_addr[ADDR_W-2:2], 2'b00};
    hit_len  = (ofs == LEN_OFS);
    hit_stat = (ofs == STAT_OFS);
    hit_data = (ofs < LEN_OFS);
  end

  for (genvar b = 0; b < 2; b++) begin : g_buf
    logic wr_b, stat_wr, len_wr, done_hit;

    always_comb begin
      wr_b     = bus_wr && (sel_b == 1'(b));
      stat_wr  = wr_b && hit_stat;
      len_wr   = wr_b && hit_len && !st[b].busy;
      done_hit = done && (done_buf == 1'(b));
      kill[b]  = stat_wr && !bus_wdata[ST_BUSY] && st[b].busy;
      pend[b]  = st[b].busy && !st[b].taken && !kill[b];
      busy_v[b] = st[b].busy;
      ie_v[b]   = st[b].ie;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        st[b] <= '0;
      end else begin
        if (len_wr) st[b].len <= bus_wdata[LEN_W-1:0];
        if (done_hit) begin
          st[b].busy  <= 1'b0;
          st[b].prog  <= 1'b0;
          st[b].taken <= 1'b0;
        end
        if (start_fire && start_buf == 1'(b)) st[b].taken <= 1'b1;
        if (stat_wr) begin
          st[b].ie   <= bus_wdata[ST_IE];
          st[b].flag <= bus_wdata[ST_FLAG];
          if (!bus_wdata[ST_BUSY]) begin
            st[b].busy  <= 1'b0;
            st[b].prog  <= 1'b0;
            st[b].taken <= 1'b0;
          end else if (!st[b].busy) begin
            st[b].busy  <= 1'b1;
            st[b].prog  <= bus_wdata[ST_PROG];
            st[b].taken <= 1'b0;
          end
        end
      end
    end
  end

  always_comb begin
    start_fire = eng_idle && (pend != 2'b00);
    start_buf  = !pend[0];
    start_prog = st[start_buf].prog;
    start_len  = (st[start_buf].len > DATA_BYTES) ? DATA_BYTES : st[start_buf].len;
    ram_we     = bus_wr && hit_data && !busy_v[sel_b];
    ram_waddr  = {sel_b, bus_addr[ADDR_W-2:2]};
    ram_wdata  = bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_irq <= 1'b0;
    end else begin
      tx_irq <= done && st[done_buf].ie && !st[done_buf].prog && !kill[done_buf];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      if (hit_len) begin
        bus_rdata[LEN_W-1:0] <= st[sel_b].len;
      end else if (hit_stat) begin
        bus_rdata[ST_BUSY] <= st[sel_b].busy;
        bus_rdata[ST_PROG] <= st[sel_b].prog;
        bus_rdata[ST_IE]   <= st[sel_b].ie;
        bus_rdata[ST_FLAG] <= st[sel_b].flag;
      end
    end
  end

endmodule

// File: rtl/dbt_engine.sv
module dbt_engine
  import dbt_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_fire,
  input  logic              start_buf,
  input  logic [LEN_W-1:0]  start_len,
  input  logic              start_prog,
  input  logic [1:0]        kill,
  output logic              eng_idle,
  output logic              done,
  output logic              cur_buf,
  output logic              cur_prog,
  output logic              ram_re,
  output logic [ADDR_W-3:0] ram_raddr,
  input  logic [31:0]       ram_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic [47:0]       station_addr
);

  localparam logic [LEN_W-1:0] ADDR_BYTES = LEN_W'(6);

  eng_state_t       state;
  logic [LEN_W-1:0] cnt, len_q, cnt_nx;
  logic [31:0]      word_q;
  logic             kill_cur, accept;

  always_comb begin
    eng_idle  = (state == E_IDLE);
    kill_cur  = kill[cur_buf] && !eng_idle;
    accept    = (state == E_SEND) && tx_valid && tx_ready;
    done      = !kill_cur && ((accept && tx_last) || state == E_FIN);
    ram_re    = (state == E_FETCH);
    ram_raddr = {cur_buf, cnt[ADDR_W-2:2]};
    cnt_nx    = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= E_IDLE;
      cnt          <= '0;
      len_q        <= '0;
      word_q       <= '0;
      cur_buf      <= 1'b0;
      cur_prog     <= 1'b0;
      tx_valid     <= 1'b0;
      tx_data      <= '0;
      tx_last      <= 1'b0;
      station_addr <= '0;
    end else if (kill_cur) begin
      state    <= E_IDLE;
      tx_valid <= 1'b0;
      tx_last  <= 1'b0;
    end else begin
      case (state)
        E_IDLE: begin
          if (start_fire) begin
            cur_buf  <= start_buf;
            cur_prog <= start_prog;
            len_q    <= start_prog ? ADDR_BYTES : start_len;
            cnt      <= '0;
            state    <= (!start_prog && start_len == '0) ? E_FIN : E_FETCH;
          end
        end
        E_FETCH: state <= E_WAIT;
        E_WAIT: begin
          if (cur_prog) begin
            if (cnt == '0) begin
              station_addr[47:16] <= ram_rdata;
              cnt   <= LEN_W'(4);
              state <= E_FETCH;
            end else begin
              station_addr[15:0] <= ram_rdata[31:16];
              state <= E_FIN;
            end
          end else begin
            word_q   <= ram_rdata;
            tx_data  <= be_byte(ram_rdata, cnt[1:0]);
            tx_last  <= (cnt_nx == len_q);
            tx_valid <= 1'b1;
            state    <= E_SEND;
          end
        end
        E_SEND: begin
          if (accept) begin
            if (tx_last) begin
              tx_valid <= 1'b0;
              tx_last  <= 1'b0;
              state    <= E_IDLE;
            end else begin
              cnt <= cnt_nx;
              if (cnt_nx[1:0] == 2'b00) begin
                tx_valid <= 1'b0;
                state    <= E_FETCH;
              end else begin
                tx_data <= be_byte(word_q, cnt_nx[1:0]);
                tx_last <= (cnt_nx + 1'b1 == len_q);
              end
            end
          end
        end
        E_FIN:   state <= E_IDLE;
        default: state <= E_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dualbuf_tx.sv
module dualbuf_tx
  import dbt_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              tx_irq,
  output logic [47:0]       station_addr
);

  localparam int RAM_AW = ADDR_W - 2;

  logic              ram_we, ram_re;
  logic [RAM_AW-1:0] ram_waddr, ram_raddr;
  logic [31:0]       ram_wdata, ram_rdata;
  logic              eng_idle, start_fire, start_buf, start_prog;
  logic [LEN_W-1:0]  start_len;
  logic              done, eng_buf, eng_prog;
  logic [1:0]        kill, busy_v, ie_v;

  dbt_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .eng_idle(eng_idle), .start_fire(start_fire), .start_buf(start_buf),
    .start_len(start_len), .start_prog(start_prog),
    .done(done), .done_buf(eng_buf), .kill(kill),
    .busy_v(busy_v), .ie_v(ie_v), .tx_irq(tx_irq)
  );

  dbt_ram #(.AW(RAM_AW), .DW(32)) i_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(ram_re), .raddr(ram_raddr), .rdata(ram_rdata)
  );

  dbt_engine #(.ADDR_W(ADDR_W)) i_eng (
    .clk(clk), .rst(rst),
    .start_fire(start_fire), .start_buf(start_buf),
    .start_len(start_len), .start_prog(start_prog),
    .kill(kill), .eng_idle(eng_idle), .done(done),
    .cur_buf(eng_buf), .cur_prog(eng_prog),
    .ram_re(ram_re), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .station_addr(station_addr)
  );

endmodule

// File: rtl/dualbuf_tx_chk.sv
module dualbuf_tx_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_wr,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       tx_last,
  input logic       tx_irq,
  input logic [1:0] busy_v,
  input logic [1:0] ie_v,
  input logic       eng_buf,
  input logic       eng_prog
);

  logic [1:0] sel_oh;
  always_comb sel_oh = eng_buf ? 2'b10 : 2'b01;

  // R3: a stalled byte is held unchanged
  a_r3_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !bus_wr) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R4: busy of the sending buffer is clear right after its last byte
  a_r4_busy_clears: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && tx_last && !bus_wr) |=> ((busy_v & $past(sel_oh)) == 2'b00));

  // R5: interrupt is a single-cycle pulse
  a_r5_irq_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_irq |=> !tx_irq);

  // R5: interrupt only follows a busy buffer with enable set
  a_r5_irq_cause: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> $past((busy_v & ie_v) != 2'b00));

  // R6: an address load never drives the stream
  a_r6_prog_silent: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !eng_prog);

  // R10: bytes are offered only from a buffer that is still busy
  a_r10_valid_needs_busy: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> ((busy_v & sel_oh) != 2'b00));

endmodule

bind dualbuf_tx dualbuf_tx_chk i_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_last(tx_last), .tx_irq(tx_irq),
  .busy_v(busy_v), .ie_v(ie_v), .eng_buf(eng_buf), .eng_prog(eng_prog)
);

// File: tb/test_dualbuf_tx.sv
`timescale 1ns/1ps
module test_dualbuf_tx;

  localparam int ADDR_W = 12;
  localparam logic [11:0] PONG = 12'h800;
  localparam logic [11:0] LENO = 12'h7F4;
  localparam logic [11:0] STAO = 12'h7FC;
  localparam int NVEC = 6;
  // {buf, ie, stall, len[15:0], seed[7:0]}
  localparam logic [26:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 1'b0, 16'd5,  8'h11},
    {1'b1, 1'b0, 1'b1, 16'd8,  8'h22},
    {1'b0, 1'b0, 1'b0, 16'd1,  8'h33},
    {1'b1, 1'b1, 1'b1, 16'd13, 8'h44},
    {1'b0, 1'b1, 1'b1, 16'd4,  8'h55},
    {1'b1, 1'b0, 1'b0, 16'd20, 8'h66}
  };

  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tx_valid, tx_ready, tx_last, tx_irq;
  logic [7:0] tx_data;
  logic [47:0] station_addr;

  int n_chk = 0, n_fail = 0;
  int rx_n = 0, irq_cnt = 0, cyc = 0;
  logic [7:0] rx_data [4096];
  logic       rx_lst  [4096];
  logic ready_hold = 0, stall_en = 0;

  always #5 clk = ~clk;

  dualbuf_tx #(.ADDR_W(ADDR_W)) i_dualbuf_tx (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .tx_irq(tx_irq), .station_addr(station_addr)
  );

  initial begin
    tx_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      cyc++;
      tx_ready = ready_hold ? 1'b0 : (stall_en ? (cyc % 3 != 0) : 1'b1);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (tx_valid && tx_ready && rx_n < 4096) begin
        rx_data[rx_n] = tx_data;
        rx_lst[rx_n]  = tx_last;
        rx_n++;
      end
      if (tx_irq) irq_cnt++;
    end
  end

  function automatic logic [7:0] pat(input logic [7:0] s, input int i);
    return 8'((int'(s) * 7) + i * 13 + 1);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_rd = 1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic fill(input logic [11:0] base, input logic [7:0] s, input int len);
    for (int w = 0; w < (len + 3) / 4; w++)
      wr(base + 12'(4 * w), {pat(s, 4*w), pat(s, 4*w+1), pat(s, 4*w+2), pat(s, 4*w+3)});
  endtask

  task automatic wait_idle(input logic [11:0] base);
    logic [31:0] d;
    for (int i = 0; i < 5000; i++) begin
      rd(base + STAO, d);
      if (!d[0]) break;
    end
    idle(2);
  endtask

  task automatic cmp_frame(input string req, input int ofs, input logic [7:0] s, input int len);
    int bad = 0;
    for (int i = 0; i < len; i++) begin
      if (rx_data[ofs+i] !== pat(s, i)) bad++;
      if (rx_lst[ofs+i] !== ((ofs + i) == rx_n - 1)) bad++;
    end
    check(req, 64'(bad), 64'd0);
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int i0;
    idle(3);
    rst = 0;
    idle(1);

    // R1 reset state
    rd(STAO, d);        check("R1 ping status", 64'(d), 64'd0);
    rd(PONG + STAO, d); check("R1 pong status", 64'(d), 64'd0);
    rd(LENO, d);        check("R1 ping length", 64'(d), 64'd0);
    check("R1 tx_valid", 64'(tx_valid), 64'd0);
    check("R1 station_addr", 64'(station_addr), 64'd0);

    // R2 register map and readback widths
    wr(PONG + LENO, 32'hABCD_1234);
    rd(PONG + LENO, d); check("R2 length low 16 bits", 64'(d), 64'h1234);
    rd(LENO, d);        check("R2 ping length separate", 64'(d), 64'd0);

    // R7 software flag: reads back, launches nothing
    rx_n = 0;
    wr(STAO, 32'hFFFF_FFF6);
    rd(STAO, d); check("R2 R7 status unused bits zero", 64'(d), 64'h8000_0000);
    wr(STAO, 32'h8000_0008);
    idle(10);
    rd(STAO, d); check("R7 flag readback, busy 0", 64'(d), 64'h8000_0008);
    check("R7 no bytes from flag", 64'(rx_n), 64'd0);

    // R3 R4 R5 vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [11:0] base;
      int len;
      base = VEC[v][26] ? PONG : 12'h000;
      len  = int'(VEC[v][23:8]);
      stall_en = VEC[v][24];
      fill(base, VEC[v][7:0], len);
      wr(base + LENO, 32'(len));
      rx_n = 0; i0 = irq_cnt;
      wr(base + STAO, {28'd0, VEC[v][25], 3'b001});
      wait_idle(base);
      check("R3 byte count", 64'(rx_n), 64'(len));
      cmp_frame("R3 bytes and last flag", 0, VEC[v][7:0], len);
      rd(base + STAO, d); check("R4 busy cleared", 64'(d[0]), 64'd0);
      check("R5 interrupt count", 64'(irq_cnt - i0), 64'(VEC[v][25]));
      stall_en = 0;
    end

    // R6 station address load with length 9
    wr(12'h000, 32'h0A0B_0C0D);
    wr(12'h004, 32'h0E0F_AAAA);
    wr(LENO, 32'd9);
    rx_n = 0; i0 = irq_cnt;
    wr(STAO, 32'h0000_000B);
    wait_idle(12'h000);
    check("R6 station_addr", 64'(station_addr), 64'h0A0B_0C0D_0E0F);
    check("R6 no stream bytes", 64'(rx_n), 64'd0);
    check("R5 R6 no irq on program", 64'(irq_cnt - i0), 64'd0);
    rd(STAO, d); check("R6 bits 0,1 cleared", 64'(d), 64'h8);

    // R8 launch order: pong then ping
    ready_hold = 1;
    fill(PONG, 8'h80, 3); wr(PONG + LENO, 32'd3);
    fill(12'h000, 8'h70, 3); wr(LENO, 32'd3);
    rx_n = 0;
    wr(PONG + STAO, 32'h1);
    wr(STAO, 32'h1);
    idle(4);
    check("R3 stalled byte held", {55'd0, tx_valid, tx_data}, {55'd0, 1'b1, pat(8'h80, 0)});
    ready_hold = 0;
    wait_idle(12'h000);
    wait_idle(PONG);
    check("R8 total bytes", 64'(rx_n), 64'd6);
    begin
      int bad = 0;
      for (int i = 0; i < 3; i++) begin
        if (rx_data[i]   !== pat(8'h80, i)) bad++;
        if (rx_data[i+3] !== pat(8'h70, i)) bad++;
      end
      if (rx_lst[2] !== 1'b1 || rx_lst[5] !== 1'b1) bad++;
      check("R8 order pong then ping", 64'(bad), 64'd0);
    end

    // R9 writes to a busy buffer are ignored
    ready_hold = 1;
    fill(12'h000, 8'h90, 4); wr(LENO, 32'd4);
    rx_n = 0;
    wr(STAO, 32'h1);
    wr(12'h000, 32'hDEAD_BEEF);
    wr(LENO, 32'd2);
    rd(LENO, d); check("R9 length unchanged while busy", 64'(d), 64'd4);
    ready_hold = 0;
    wait_idle(12'h000);
    check("R9 byte count", 64'(rx_n), 64'd4);
    cmp_frame("R9 data unchanged", 0, 8'h90, 4);

    // R10 cancel a stalled frame
    ready_hold = 1;
    fill(PONG, 8'hA0, 8); wr(PONG + LENO, 32'd8);
    rx_n = 0; i0 = irq_cnt;
    wr(PONG + STAO, 32'h9);
    idle(5);
    wr(PONG + STAO, 32'h0);
    rd(PONG + STAO, d); check("R10 status idle", 64'(d), 64'd0);
    ready_hold = 0;
    idle(20);
    check("R10 no bytes after cancel", 64'(rx_n), 64'd0);
    check("R10 no irq after cancel", 64'(irq_cnt - i0), 64'd0);
    wr(PONG + LENO, 32'd2);
    wr(PONG + STAO, 32'h1);
    wait_idle(PONG);
    check("R10 relaunch count", 64'(rx_n), 64'd2);
    cmp_frame("R10 relaunch bytes", 0, 8'hA0, 2);

    // R11 zero and oversized lengths
    wr(LENO, 32'd0);
    rx_n = 0; i0 = irq_cnt;
    wr(STAO, 32'h9);
    wait_idle(12'h000);
    rd(STAO, d); check("R11 zero length busy cleared", 64'(d[0]), 64'd0);
    check("R11 zero length no bytes", 64'(rx_n), 64'd0);
    check("R11 zero length irq", 64'(irq_cnt - i0), 64'd1);
    wr(LENO, 32'hFFFF);
    rx_n = 0;
    wr(STAO, 32'h1);
    wait_idle(12'h000);
    check("R11 clamped byte count", 64'(rx_n), 64'd2036);
    check("R11 last on final byte", 64'(rx_lst[2035]), 64'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule